// File: doc/BRIEF.md
# Weighted Egress Queue Scheduler

This block sits at one egress port and decides which of its four transmit priority queues sends the next packet. A queue competes only when it holds data and its rate pacer currently lets it send. A queue the pacer is holding back simply drops out, so a lower queue can use the link in the meantime. After a grant the block waits for the packet-finished handshake before it makes the next decision. While it waits, the granted queue is held on the grant output.

A mode input selects one of two policies. In strict mode the highest-numbered requesting queue always wins. In weighted mode a 16-slot schedule gives queues 3, 2, 1 and 0 a 9:4:2:1 share when all four are backlogged. The schedule spreads each queue's turns through the round instead of serving them back to back. A slot pointer walks the schedule and passes over slots whose queue is not requesting. The scheduler is work-conserving: whenever it is idle and any queue requests, it grants one.

Top module: `egress_qsched`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, grant is 4'b0000 and grant_valid is 0.
- R2: In strict mode (strict_mode=1) the granted queue is the highest-numbered requesting queue, with queue 3 highest.
- R3: A queue requests only when both its bit in q_nonempty and its bit in q_eligible are 1. A queue that is empty or ineligible is never granted.
- R4: If no packet is outstanding and any queue requests in a cycle, grant_valid is 1 in the next cycle.
- R5: After a grant, grant keeps the same value and no new grant_valid appears until pkt_done is 1 in some cycle. grant returns to 0 in the cycle after that. A pkt_done with no packet outstanding has no effect.
- R6: grant_valid is a one-cycle strobe, and while it is 1, grant is one-hot with bit i meaning queue i. grant is 0 while no packet is outstanding.
- R7: In weighted mode (strict_mode=0) the schedule slots 0..15 serve queues 3,2,3,1,3,2,3,0,3,2,3,1,3,2,3,3. With all four queues requesting, 16 consecutive decisions from slot 0 follow that order, which gives 9, 4, 2 and 1 grants to queues 3, 2, 1 and 0.
- R8: In weighted mode a decision searches forward, wrapping, from the current slot. It serves the first slot whose queue requests, and the pointer moves to the slot after that one.
- R9: When strict_mode changes, the slot pointer returns to slot 0, and the new mode governs the first decision made in or after the cycle of the change.
- R10: When no queue requests and no packet is outstanding, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| q_nonempty | input | 4 | Bit i set when queue i holds a packet |
| q_eligible | input | 4 | Bit i set when the rate pacer allows queue i to send |
| strict_mode | input | 1 | 1 selects strict priority, 0 selects weighted round-robin |
| pkt_done | input | 1 | Outstanding packet has finished |
| grant | output | 4 | One-hot queue being served, held until done |
| grant_valid | output | 1 | One-cycle strobe marking a new grant |

## Verification
The bench goes after pointer handling in weighted mode. It checks the wrap from slot 15 back to slot 0, and it checks skips over runs of slots whose queue is empty or paced. A design that advanced the pointer by one slot instead of past the served slot would repeat queue 3 and break the 9:4:2:1 order. The bench flips the mode between decisions. A design that kept the stale pointer would start the next weighted round at the wrong queue. It also sends pkt_done while nothing is outstanding, and it drops eligibility on the queue that would otherwise win. A design that let either of these leak through would issue a spurious grant or serve a paced queue.

// File: rtl/egress_qsched_pkg.sv
// Package: shared sizes and the weighted schedule for the egress queue scheduler.
// Assumes exactly four queues; the schedule is derived from the slot index.
package egress_qsched_pkg;
    localparam int NUM_Q     = 4;
    localparam int NUM_SLOTS = 16;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int QIDX_W    = $clog2(NUM_Q);

    // Queue served by a slot: even slots and the final slot go to queue 3,
    // odd slots at 1 mod 4 to queue 2, slots 3 and 11 to queue 1, slot 7 to queue 0.
    function automatic logic [QIDX_W-1:0] slot_queue(input logic [SLOT_W-1:0] s);
        logic [QIDX_W-1:0] q;
        if (!s[0] || s == SLOT_W'(NUM_SLOTS - 1)) q = QIDX_W'(3);
        else if (s[1] == 1'b0)                    q = QIDX_W'(2);
        else if (s[2] == 1'b0)                    q = QIDX_W'(1);
        else                                      q = QIDX_W'(0);
        return q;
    endfunction
endpackage

// File: rtl/qsched_strict_pick.sv
// Module: strict priority picker. Returns a one-hot of the highest set request bit.
// Assumes nothing about the request vector; returns zero when it is zero.
module qsched_strict_pick
    import egress_qsched_pkg::*;
#(
    parameter int NQ = NUM_Q
) (
    input  logic [NQ-1:0] req,
    output logic [NQ-1:0] pick
);
    // Scan upward so the last (highest) set bit wins.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NQ; i++) begin
            if (req[i]) pick = NQ'(1) << i;
        end
    end
endmodule

// File: rtl/qsched_wrr_pick.sv
// Module: weighted slot picker. Searches the 16-slot schedule from a start slot,
// wrapping, for the first slot whose queue requests.
// Assumes the caller applies the pointer update only when a grant is taken.
module qsched_wrr_pick
    import egress_qsched_pkg::*;
#(
    parameter int NQ    = NUM_Q,
    parameter int SLOTS = NUM_SLOTS,
    parameter int SW    = SLOT_W
) (
    input  logic [NQ-1:0] req,
    input  logic [SW-1:0] start,
    output logic [NQ-1:0] pick,
    output logic [SW-1:0] next_slot
);
    // First-match search across one full revolution of the schedule.
    always_comb begin
        logic          found;
        logic [SW-1:0] idx;
        logic [QIDX_W-1:0] q;
        found     = 1'b0;
        pick      = '0;
        next_slot = start;
        for (int k = 0; k < SLOTS; k++) begin
            idx = start + SW'(k);
            q   = slot_queue(idx);
            if (!found && req[q]) begin
                found     = 1'b1;
                pick      = NQ'(1) << q;
                next_slot = idx + SW'(1);
            end
        end
    end
endmodule

// File: rtl/egress_qsched.sv
// Module: egress queue scheduler top. Holds one outstanding grant until done,
// picks strict or weighted per strict_mode, keeps the weighted slot pointer.
// Assumes pkt_done is asserted only for the packet currently granted.
module egress_qsched
    import egress_qsched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] q_nonempty,
    input  logic [NUM_Q-1:0] q_eligible,
    input  logic             strict_mode,
    input  logic             pkt_done,
    output logic [NUM_Q-1:0] grant,
    output logic             grant_valid
);
    logic [NUM_Q-1:0]  req;
    logic [NUM_Q-1:0]  strict_pick, wrr_pick, chosen;
    logic [SLOT_W-1:0] ptr_q, ptr_eff, wrr_next;
    logic [NUM_Q-1:0]  grant_q;
    logic              valid_q, mode_q, busy, decide, mode_flip;

    // Requesting queues: holding data and allowed by the pacer.
    assign req       = q_nonempty & q_eligible;
    assign busy      = |grant_q;
    assign mode_flip = (strict_mode != mode_q);
    assign ptr_eff   = mode_flip ? '0 : ptr_q;
    assign decide    = !busy && (|req);

    qsched_strict_pick #(.NQ(NUM_Q)) u_strict (
        .req  (req),
        .pick (strict_pick)
    );

    qsched_wrr_pick #(.NQ(NUM_Q), .SLOTS(NUM_SLOTS), .SW(SLOT_W)) u_wrr (
        .req       (req),
        .start     (ptr_eff),
        .pick      (wrr_pick),
        .next_slot (wrr_next)
    );

    // Policy selection for the current decision.
    assign chosen = strict_mode ? strict_pick : wrr_pick;

    // Grant register, strobe and outstanding tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            valid_q <= 1'b0;
        end else if (decide) begin
            grant_q <= chosen;
            valid_q <= 1'b1;
        end else begin
            valid_q <= 1'b0;
            if (busy && pkt_done) grant_q <= '0;
        end
    end

    // Slot pointer and remembered mode for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= strict_mode;
            if (decide && !strict_mode) ptr_q <= wrr_next;
            else                        ptr_q <= ptr_eff;
        end
    end

    assign grant       = grant_q;
    assign grant_valid = valid_q;
endmodule

// File: rtl/egress_qsched_chk.sv
// Module: assertion checker for egress_qsched, bound to every instance.
// Assumes it sees only the top-level ports.
module egress_qsched_chk
    import egress_qsched_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_Q-1:0] q_nonempty,
    input logic [NUM_Q-1:0] q_eligible,
    input logic             strict_mode,
    input logic             pkt_done,
    input logic [NUM_Q-1:0] grant,
    input logic             grant_valid
);
    logic [NUM_Q-1:0] rq;
    assign rq = q_nonempty & q_eligible;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (grant == '0 && !grant_valid)); // R1
    AST_STRICT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(strict_mode)) |-> (($past(rq) & ~({grant[NUM_Q-2:0], 1'b0} - NUM_Q'(1))) == '0)); // R2
    AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((grant & $past(rq)) != '0)); // R3
    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && rq != '0) |=> grant_valid); // R4
    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !pkt_done) |=> $stable(grant)); // R5
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> !grant_valid); // R5
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant) == 1)); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && rq == '0) |=> !grant_valid); // R10
endmodule

bind egress_qsched egress_qsched_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_nonempty  (q_nonempty),
    .q_eligible  (q_eligible),
    .strict_mode (strict_mode),
    .pkt_done    (pkt_done),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/sim_egress_qsched.sv
// Bench: behavioural reference model compared against the scheduler every cycle.
module sim_egress_qsched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] q_nonempty = '0;
    logic [3:0] q_eligible = '0;
    logic       strict_mode = 1'b0;
    logic       pkt_done = 1'b0;
    logic [3:0] grant;
    logic       grant_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int seq [16] = '{3,2,3,1,3,2,3,0,3,2,3,1,3,2,3,3};

    // Reference model state.
    int m_busy, m_grant, m_valid, m_ptr, m_mode;
    int tally [4];

    always #2.5 clk = ~clk;

    egress_qsched u0 (
        .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_eligible(q_eligible),
        .strict_mode(strict_mode), .pkt_done(pkt_done), .grant(grant), .grant_valid(grant_valid)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: an overlong run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
            summary();
        end
    end

    task automatic compare(input string tag);
        n_cmp++;
        if (grant_valid !== 1'(m_valid) || grant !== 4'(m_grant)) begin
            n_bad++;
            $display("FAIL %s: actual valid=%0b grant=%b, expected valid=%0d grant=%b",
                     tag, grant_valid, grant, m_valid, 4'(m_grant));
        end
        if (grant_valid === 1'b1)
            for (int q = 0; q < 4; q++) if (grant[q]) tally[q]++;
    endtask

    // One cycle: drive inputs after a falling edge, predict, compare at the next falling edge.
    task automatic step(input logic [3:0] ne, input logic [3:0] el, input logic md,
                        input logic dn, input string tag);
        int req, pick;
        q_nonempty = ne; q_eligible = el; strict_mode = md; pkt_done = dn;
        req = int'(ne & el);
        if (int'(md) != m_mode) m_ptr = 0;
        m_mode = int'(md);
        if (m_busy == 0 && req != 0) begin
            pick = -1;
            if (md) begin
                for (int q = 0; q < 4; q++) if (req[q]) pick = q;
            end else begin
                for (int k = 0; k < 16; k++) begin
                    int s;
                    s = (m_ptr + k) % 16;
                    if (pick < 0 && req[seq[s]]) begin
                        pick = seq[s];
                        m_ptr = (s + 1) % 16;
                    end
                end
            end
            m_busy = 1; m_grant = 1 << pick; m_valid = 1;
        end else begin
            m_valid = 0;
            if (m_busy != 0 && dn) begin m_busy = 0; m_grant = 0; end
        end
        @(negedge clk);
        compare(tag);
    endtask

    // Grant, hold one cycle, then finish the packet.
    task automatic serve(input logic [3:0] ne, input logic [3:0] el, input logic md, input string tag);
        step(ne, el, md, 1'b0, tag);
        step(ne, el, md, 1'b0, {tag, "_hold"});
        step(ne, el, md, 1'b1, {tag, "_done"});
    endtask

    initial begin
        m_busy = 0; m_grant = 0; m_valid = 0; m_ptr = 0; m_mode = 0;
        for (int q = 0; q < 4; q++) tally[q] = 0;
        q_nonempty = 4'hF; q_eligible = 4'hF;
        repeat (3) @(negedge clk);
        compare("R1_in_reset");
        rst_n = 1'b1;
        q_nonempty = '0; q_eligible = '0;
        @(negedge clk);
        compare("R1_after_reset");

        // R10: nothing requesting, stray done while idle (R5).
        step(4'h0, 4'hF, 1'b0, 1'b0, "R10_idle");
        step(4'hF, 4'h0, 1'b0, 1'b1, "R5_done_idle");
        step(4'h0, 4'h0, 1'b1, 1'b1, "R10_idle_strict");

        // R2: strict priority with several patterns; R3 with pacing.
        serve(4'hF, 4'hF, 1'b1, "R2_all");
        serve(4'h6, 4'hF, 1'b1, "R2_q21");
        serve(4'h3, 4'hF, 1'b1, "R2_q10");
        serve(4'hF, 4'h7, 1'b1, "R3_q3_paced");
        serve(4'hC, 4'h5, 1'b1, "R3_mixed");
        serve(4'h1, 4'h1, 1'b1, "R2_q0_only");

        // R4/R5: long hold with changing requests, then done.
        step(4'hF, 4'hF, 1'b1, 1'b0, "R4_grant");
        for (int i = 0; i < 5; i++) step(4'(i), 4'hF, 1'b1, 1'b0, "R5_held");
        step(4'h2, 4'hF, 1'b1, 1'b1, "R5_release");
        step(4'h2, 4'hF, 1'b1, 1'b0, "R4_next");
        step(4'h0, 4'h0, 1'b1, 1'b1, "R5_release2");

        // R9 + R7: switch to weighted, full round with all requesting.
        for (int q = 0; q < 4; q++) tally[q] = 0;
        for (int i = 0; i < 16; i++) serve(4'hF, 4'hF, 1'b0, "R7_round");
        n_cmp++;
        if (tally[3] != 9 || tally[2] != 4 || tally[1] != 2 || tally[0] != 1) begin
            n_bad++;
            $display("FAIL R7 ratio: actual %0d/%0d/%0d/%0d, expected 9/4/2/1",
                     tally[3], tally[2], tally[1], tally[0]);
        end

        // R8: skipping and wrap with sparse requests.
        serve(4'h3, 4'hF, 1'b0, "R8_q10");
        serve(4'h3, 4'hF, 1'b0, "R8_q10b");
        serve(4'h3, 4'hF, 1'b0, "R8_q10c");
        serve(4'hF, 4'h1, 1'b0, "R8_q0_only");
        serve(4'hF, 4'hB, 1'b0, "R8_no_q2");
        for (int i = 0; i < 20; i++) serve(4'(i * 7 + 3), 4'(i * 5 + 9), 1'b0, "R8_mix");

        // R9: mode flips between decisions and within an outstanding packet.
        serve(4'hF, 4'hF, 1'b0, "R9_pre");
        serve(4'hF, 4'hF, 1'b1, "R9_to_strict");
        serve(4'h6, 4'hF, 1'b0, "R9_back_wrr");
        serve(4'hF, 4'hF, 1'b0, "R9_wrr2");
        step(4'hF, 4'hF, 1'b0, 1'b0, "R9_grant");
        step(4'hF, 4'hF, 1'b1, 1'b0, "R9_flip_busy");
        step(4'hF, 4'hF, 1'b0, 1'b1, "R9_flip_back_done");
        serve(4'hF, 4'hF, 1'b0, "R9_after");
        for (int i = 0; i < 12; i++) serve(4'(i * 3 + 1), 4'hF, 1'(i % 3 == 0), "R9_mix");

        summary();
    end
endmodule